// File: doc/BRIEF.md
# Link Power Status Monitor

This block watches the power-status level that the link-layer controller drives toward the PHY and sets the power state of the PHY-to-link interface from it. The status input is asynchronous. It passes through a two-stage synchroniser clocked by the PHY-side sample clock, and a counter measures how many consecutive samples have been low. Two low-time limits give three interface states, so a pulsed status signal with short low phases counts as a powered link.

The three states are Active, LowPowerReset and Disabled. In Active the interface runs normally. In LowPowerReset the control and data lines are forced to zero and link requests are ignored, but the PHY clock keeps running. In Disabled the PHY clock is also stopped. The state has these transitions:

- Active→LowPowerReset: the low run passes the first limit.
- LowPowerReset→Disabled: the low run passes the second limit.
- LowPowerReset→Active and Disabled→Active: one synchronised high sample.
- Hardware reset→Disabled.

The link-active bit that goes into the self-ID packet is the link-control register bit gated by the Active state.

The sample clock period must not exceed 22 ns, so that the shortest legal high pulse is always caught. At 49.152 MHz the default limits of 128 and 1280 cycles match about 2.6 µs and 26 µs.

Top module: `link_power_monitor`

## Requirements
- R1: While rst_n is low, and after it is released while lps_in stays low, the block is Disabled: force_zero=1, ignore_req=1, phy_clk_en=0, link_active=0.
- R2: lps_in passes through two synchroniser flops. Each clock edge that sees a synchronised low adds one to a low-run count, and any synchronised high clears it. If lps_in is low from just after edge 0, edges 3, 4, ... count 1, 2, ...
- R3: Active→LowPowerReset happens at the edge where the count already exceeds RESET_LIMIT. With lps_in held low from just after edge 0, the outputs change just after edge RESET_LIMIT+4.
- R4: In LowPowerReset: force_zero=1, ignore_req=1, phy_clk_en=1.
- R5: LowPowerReset→Disabled happens at the edge where the count already exceeds DISABLE_LIMIT, which is just after edge DISABLE_LIMIT+4 for the held low above. In Disabled, phy_clk_en=0 and force_zero=ignore_req=1.
- R6: A pulse train whose low phases last at most RESET_LIMIT+1 clock cycles, with high phases of at least one cycle, never leaves Active. A low phase of RESET_LIMIT+2 cycles does reach LowPowerReset.
- R7: From LowPowerReset or Disabled, a high on lps_in driven just after edge k gives Active outputs just after edge k+3. The outputs are unchanged just after edges k+1 and k+2.
- R8: In Active: force_zero=0, ignore_req=0, phy_clk_en=1.
- R9: link_active equals link_ctrl while Active and is 0 in the other states. It follows link_ctrl with no clock delay.
- R10: Active never goes straight to Disabled: one clock after Active, phy_clk_en is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-side sample clock, period at most 22 ns |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| lps_in | input | 1 | Asynchronous link power-status level |
| link_ctrl | input | 1 | Link-control register bit |
| force_zero | output | 1 | Holds control and data lines at logic 0 |
| ignore_req | output | 1 | Ignore link requests |
| phy_clk_en | output | 1 | PHY clock output enable |
| link_active | output | 1 | Link-active bit for the self-ID packet |

## Verification
A wrong state shows at once on force_zero, ignore_req and phy_clk_en, because all three are decoded directly from the state register. A count that is cleared too late, or that never clears, moves the entry into LowPowerReset or Disabled by at least one cycle. It can also make a short-low pulse train drop out of Active. A wrong synchroniser depth shifts the return to Active away from edge k+3. The bench compares every cycle of a held low against the arithmetic edge numbers, so an error shows as a mismatch on the first cycle it affects.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_LP_RESET = 2'd1,
        ST_DISABLED = 2'd2
    } lpm_state_t;

    typedef struct packed {
        logic force_zero;
        logic ignore_req;
        logic phy_clk_en;
    } lpm_ctrl_t;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer #(
    parameter int RESET_LIMIT   = 128,
    parameter int DISABLE_LIMIT = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_s,
    output logic over_reset,
    output logic over_disable
);
    localparam int SAT   = DISABLE_LIMIT + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        run_q <= '0;
        else if (level_s)                  run_q <= '0;
        else if (run_q != CNT_W'(SAT))     run_q <= run_q + 1'b1;
    end

    assign over_reset   = (run_q > CNT_W'(RESET_LIMIT));
    assign over_disable = (run_q > CNT_W'(DISABLE_LIMIT));
endmodule

// File: rtl/lpm_state_ctrl.sv
module lpm_state_ctrl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_s,
    input  logic       over_reset,
    input  logic       over_disable,
    output lpm_state_t state,
    output lpm_ctrl_t  ctrl
);
    lpm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (!level_s && over_reset) state_d = ST_LP_RESET;
            end
            ST_LP_RESET: begin
                if (level_s)           state_d = ST_ACTIVE;
                else if (over_disable) state_d = ST_DISABLED;
            end
            ST_DISABLED: begin
                if (level_s) state_d = ST_ACTIVE;
            end
            default: state_d = ST_DISABLED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISABLED;
        else        state_q <= state_d;
    end

    always_comb begin
        ctrl = '{force_zero: 1'b1, ignore_req: 1'b1, phy_clk_en: 1'b0};
        unique case (state_q)
            ST_ACTIVE:   ctrl = '{force_zero: 1'b0, ignore_req: 1'b0, phy_clk_en: 1'b1};
            ST_LP_RESET: ctrl = '{force_zero: 1'b1, ignore_req: 1'b1, phy_clk_en: 1'b1};
            ST_DISABLED: ctrl = '{force_zero: 1'b1, ignore_req: 1'b1, phy_clk_en: 1'b0};
            default:     ctrl = '{force_zero: 1'b1, ignore_req: 1'b1, phy_clk_en: 1'b0};
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/link_power_monitor.sv
module link_power_monitor
    import lpm_pkg::*;
#(
    parameter int RESET_LIMIT   = 128,
    parameter int DISABLE_LIMIT = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    input  logic link_ctrl,
    output logic force_zero,
    output logic ignore_req,
    output logic phy_clk_en,
    output logic link_active
);
    localparam int SYNC_DEPTH = 2;

    logic       lps_s;
    logic       over_reset;
    logic       over_disable;
    lpm_state_t state;
    lpm_ctrl_t  ctrl;

    lpm_sync #(.STAGES(SYNC_DEPTH)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lps_in),
        .sync_out (lps_s)
    );

    lpm_low_timer #(
        .RESET_LIMIT   (RESET_LIMIT),
        .DISABLE_LIMIT (DISABLE_LIMIT)
    ) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_s      (lps_s),
        .over_reset   (over_reset),
        .over_disable (over_disable)
    );

    lpm_state_ctrl fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_s      (lps_s),
        .over_reset   (over_reset),
        .over_disable (over_disable),
        .state        (state),
        .ctrl         (ctrl)
    );

    assign force_zero  = ctrl.force_zero;
    assign ignore_req  = ctrl.ignore_req;
    assign phy_clk_en  = ctrl.phy_clk_en;
    assign link_active = link_ctrl && (state == ST_ACTIVE);
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker (
    input logic clk,
    input logic rst_n,
    input logic lps_s,
    input logic link_ctrl,
    input logic force_zero,
    input logic ignore_req,
    input logic phy_clk_en,
    input logic link_active
);
    // R1: the first edge after reset release still shows Disabled
    a_r1_disabled_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (force_zero && !phy_clk_en));

    // R4, R5: forced lines always come with ignored requests
    a_r4_zero_implies_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |-> ignore_req);

    // R8: lines not forced means the clock runs
    a_r8_active_clock_runs: assert property (@(posedge clk) disable iff (!rst_n)
        !force_zero |-> phy_clk_en);

    // R9: link_active only with link_ctrl set and the interface active
    a_r9_link_active_gate: assert property (@(posedge clk) disable iff (!rst_n)
        link_active |-> (link_ctrl && !force_zero));

    // R10: no single-step move from Active into Disabled
    a_r10_no_direct_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !force_zero |=> phy_clk_en);

    // R7: a synchronised high brings Active on the next edge
    a_r7_wake_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        lps_s |=> !force_zero);

    // R5: the clock stops only while the synchronised input is low
    a_r5_stop_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_clk_en) |-> !$past(lps_s));
endmodule

bind link_power_monitor lpm_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lps_s       (lps_s),
    .link_ctrl   (link_ctrl),
    .force_zero  (force_zero),
    .ignore_req  (ignore_req),
    .phy_clk_en  (phy_clk_en),
    .link_active (link_active)
);

// File: tb/link_power_monitor_tb.sv
module link_power_monitor_tb_top;
    localparam int RL = 6;
    localparam int DL = 20;
    localparam int S_ACT = 0;
    localparam int S_RST = 1;
    localparam int S_DIS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_in = 1'b0;
    logic link_ctrl = 1'b0;
    logic force_zero, ignore_req, phy_clk_en, link_active;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    link_power_monitor #(.RESET_LIMIT(RL), .DISABLE_LIMIT(DL)) dut_i (
        .clk (clk), .rst_n (rst_n), .lps_in (lps_in), .link_ctrl (link_ctrl),
        .force_zero (force_zero), .ignore_req (ignore_req),
        .phy_clk_en (phy_clk_en), .link_active (link_active)
    );

    task automatic check_state(input int exp, input string req);
        logic ef, ei, ec, ea;
        ef = (exp != S_ACT);
        ei = (exp != S_ACT);
        ec = (exp != S_DIS);
        ea = (exp == S_ACT) && link_ctrl;
        checks++;
        if ({force_zero, ignore_req, phy_clk_en, link_active} !== {ef, ei, ec, ea}) begin
            errors++;
            $display("FAIL %s t=%0t actual fz/ir/ce/la=%b%b%b%b expected=%b%b%b%b",
                     req, $time, force_zero, ignore_req, phy_clk_en, link_active,
                     ef, ei, ec, ea);
        end
    endtask

    task automatic check_link(input int exp, input string req);
        for (int v = 0; v < 2; v++) begin
            link_ctrl = v[0];
            #1;
            check_state(exp, req);
        end
        link_ctrl = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : stim
        int exp;
        bit seen;
        @(negedge clk);
        check_state(S_DIS, "R1 in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 1; j <= 8; j++) begin
            @(negedge clk);
            check_state(S_DIS, "R1 low after release");
        end
        check_link(S_DIS, "R9 disabled");

        // Wake from Disabled: R7
        lps_in = 1'b1;
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            check_state(j >= 3 ? S_ACT : S_DIS, "R7 wake from disabled");
        end
        check_link(S_ACT, "R9 active R8");

        // Held low sweep: R2 R3 R4 R5 R10
        lps_in = 1'b0;
        for (int j = 1; j <= DL + 6; j++) begin
            @(negedge clk);
            exp = (j >= DL + 4) ? S_DIS : (j >= RL + 4) ? S_RST : S_ACT;
            check_state(exp, j >= DL + 4 ? "R5 disabled" :
                             j >= RL + 4 ? "R3 R4 lp reset" : "R2 still active");
        end

        // Wake from Disabled again
        lps_in = 1'b1;
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            check_state(j >= 3 ? S_ACT : S_DIS, "R7 wake after held low");
        end

        // Enter LowPowerReset, then return: R4 R7
        lps_in = 1'b0;
        for (int j = 1; j <= RL + 6; j++) begin
            @(negedge clk);
            check_state(j >= RL + 4 ? S_RST : S_ACT, "R3 entry timing");
        end
        check_link(S_RST, "R9 lp reset");
        lps_in = 1'b1;
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            check_state(j >= 3 ? S_ACT : S_RST, "R7 wake from lp reset");
        end

        // Pulse trains with short low phases: R6 R2
        for (int w = 1; w <= RL + 1; w++) begin
            for (int rep = 0; rep < 3; rep++) begin
                lps_in = 1'b0;
                repeat (w) begin
                    @(negedge clk);
                    check_state(S_ACT, "R6 short-low train");
                end
                lps_in = 1'b1;
                @(negedge clk);
                check_state(S_ACT, "R6 short-low train");
            end
            repeat (3) @(negedge clk);
        end

        // Low phase of RL+2 cycles reaches LowPowerReset: R6
        seen = 1'b0;
        lps_in = 1'b0;
        for (int j = 1; j <= RL + 2; j++) begin
            @(negedge clk);
            if (j == RL + 2) lps_in = 1'b1;
        end
        @(negedge clk);
        @(negedge clk);
        seen = force_zero && phy_clk_en;
        checks++;
        if (!seen) begin
            errors++;
            $display("FAIL R6 low RL+2 actual fz=%b ce=%b expected fz=1 ce=1",
                     force_zero, phy_clk_en);
        end
        @(negedge clk);
        check_state(S_ACT, "R7 back after RL+2 low");

        // Hardware reset while active: R1
        rst_n = 1'b0;
        #1;
        check_state(S_DIS, "R1 reset while active");
        @(negedge clk);
        lps_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_state(S_DIS, "R1 after second reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule